// File: doc/BRIEF.md
# DMA Interrupt Flag and Channel Start Unit

This block holds the interrupt control word of a seven-channel DMA controller and gates the start of each channel. Each channel owns an enable bit and a completion flag. A global enable, a bus-error bit and six plain storage bits sit in the same word, with a summary bit at the top. The summary bit is set when the global enable is on and any flag is up, or when the bus-error bit is set. A single-cycle request goes to the interrupt controller's status line 3 only when the summary bit rises.

Alongside the interrupt word, the block keeps a 32-bit channel-enable word and one 32-bit control word per channel. Writing a control word with its start bit set emits a start strobe for that channel, provided that channel's enable bit in the channel-enable word is set. The transfer engines are outside this block. They report completion through one-cycle done pulses. A done pulse raises the channel's flag and drops the start bit of its control word.

Top module: `dma_irq_ctl`

## Requirements
- R1: After reset every stored bit is zero, so all reads return 0 and `irq_req` and `chan_start` are low.
- R2: A write to the interrupt word (offset 0x0F4) stores bits 5..0, bit 15 (bus error), bits 22..16 (enable of channel n in bit 16+n) and bit 23 (global enable). Bits 14..6 always read as zero.
- R3: Flag bits 30..24 (channel n in bit 24+n) are write-one-to-clear. A written 1 clears the flag and a written 0 leaves it unchanged.
- R4: A done pulse on channel n sets flag 24+n only when enable bit 16+n is set at that edge. Otherwise the pulse leaves the interrupt word unchanged.
- R5: Bit 31 of the interrupt word equals (global enable AND any flag) OR bus error after every update.
- R6: `irq_req` is high for exactly the one cycle after the edge at which bit 31 goes from 0 to 1. It stays low while bit 31 remains set or falls.
- R7: When a done pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: A write to channel n's control word (offset 0x088 + 0x10·n) with bit 24 set produces a one-cycle `chan_start[n]` in the next cycle, but only if bit 3+4·n of the channel-enable word is set. No strobe is produced otherwise.
- R9: A done pulse on channel n clears bit 24 of its control word and keeps the other bits. A write to that control word in the same cycle takes precedence over the done pulse.
- R10: The channel-enable word at offset 0x0F0 stores and returns all 32 bits. Control words store and return all 32 bits.
- R11: Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| chan_done | input | 7 | Per-channel completion pulses |
| chan_start | output | 7 | Per-channel start strobes |
| irq_req | output | 1 | Request to the interrupt controller's status line 3 |

## Verification
The assertions assume that `chan_done` is a pulse that only appears after reset has been released, and that one register write is presented per cycle. The stimulus therefore drives inputs only on falling edges, holds the write strobe for a single cycle, and releases every done line right after its edge. The scoreboard pairs each driven cycle with its predicted strobe outputs. The collision cases, where a done pulse and a clearing write or a control-word write land in the same cycle, are exercised deliberately because their outcomes depend on precedence.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int WORD_W      = 32;
   localparam int LOW_W       = 6;
   localparam int BERR_BIT    = 15;
   localparam int EN_LSB      = 16;
   localparam int GEN_BIT     = 23;
   localparam int FLAG_LSB    = 24;
   localparam int MASTER_BIT  = 31;
   localparam int START_BIT   = 24;
   localparam int PCR_EN_OFS  = 3;
   localparam int PCR_STRIDE  = 4;
   localparam int MAX_CH      = 7;

   // Offset of a channel control word, kept in one place for RTL and checker
   function automatic int unsigned ctrl_offset(input int unsigned base,
                                               input int unsigned stride,
                                               input int unsigned idx);
      return base + stride * idx;
   endfunction
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
   import dma_irq_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int NCH         = 7,
   parameter int ICR_OFS     = 'h0F4,
   parameter int PCR_OFS     = 'h0F0,
   parameter int CTRL_BASE   = 'h088,
   parameter int CTRL_STRIDE = 'h010
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_icr,
   output logic              hit_pcr,
   output logic [NCH-1:0]    hit_ctrl
);
   assign hit_icr = en && (addr == ADDR_W'(ICR_OFS));
   assign hit_pcr = en && (addr == ADDR_W'(PCR_OFS));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int unsigned OFS = ctrl_offset(CTRL_BASE, CTRL_STRIDE, i);
      assign hit_ctrl[i] = en && (addr == ADDR_W'(OFS));
   end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
   import dma_irq_pkg::*;
#(
   parameter int NCH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_icr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [NCH-1:0]    chan_done,
   output logic [WORD_W-1:0] icr_word,
   output logic              master,
   output logic              irq_req,
   output logic [NCH-1:0]    flags,
   output logic [NCH-1:0]    enables,
   output logic              gen_en,
   output logic              bus_err
);
   logic [LOW_W-1:0] low_q, low_d;
   logic             be_q, be_d;
   logic             gen_q, gen_d;
   logic [NCH-1:0]   en_q, en_d;
   logic [NCH-1:0]   fl_q, fl_d;
   logic [NCH-1:0]   clr_mask, set_mask;
   logic             ms_q, ms_d;
   logic             irq_q;
   logic             unused_wr;

   assign unused_wr = ^wr_data;

   always_comb begin
      low_d    = low_q;
      be_d     = be_q;
      gen_d    = gen_q;
      en_d     = en_q;
      clr_mask = '0;
      if (wr_icr) begin
         low_d    = wr_data[LOW_W-1:0];
         be_d     = wr_data[BERR_BIT];
         gen_d    = wr_data[GEN_BIT];
         en_d     = wr_data[EN_LSB +: NCH];
         clr_mask = wr_data[FLAG_LSB +: NCH];
      end
      // a completion beats a clearing write on the same flag
      set_mask = chan_done & en_q;
      fl_d     = (fl_q & ~clr_mask) | set_mask;
      ms_d     = (gen_d && (|fl_d)) || be_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
         be_q  <= 1'b0;
         gen_q <= 1'b0;
         en_q  <= '0;
         fl_q  <= '0;
         ms_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         low_q <= low_d;
         be_q  <= be_d;
         gen_q <= gen_d;
         en_q  <= en_d;
         fl_q  <= fl_d;
         ms_q  <= ms_d;
         irq_q <= ms_d && !ms_q;
      end
   end

   always_comb begin
      icr_word                      = '0;
      icr_word[LOW_W-1:0]           = low_q;
      icr_word[BERR_BIT]            = be_q;
      icr_word[EN_LSB +: NCH]       = en_q;
      icr_word[GEN_BIT]             = gen_q;
      icr_word[FLAG_LSB +: NCH]     = fl_q;
      icr_word[MASTER_BIT]          = ms_q;
   end

   assign master  = ms_q;
   assign irq_req = irq_q;
   assign flags   = fl_q;
   assign enables = en_q;
   assign gen_en  = gen_q;
   assign bus_err = be_q;
endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
   import dma_irq_pkg::*;
#(
   parameter int NCH       = 7,
   parameter bit START_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_pcr,
   input  logic [NCH-1:0]             wr_ctrl,
   input  logic [WORD_W-1:0]          wr_data,
   input  logic [NCH-1:0]             chan_done,
   output logic [WORD_W-1:0]          pcr_word,
   output logic [NCH-1:0][WORD_W-1:0] ctrl_word,
   output logic [NCH-1:0]             busy,
   output logic [NCH-1:0]             chan_start
);
   logic [WORD_W-1:0] pcr_q;
   logic [NCH-1:0]    start_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcr_q <= '0;
      else if (wr_pcr)  pcr_q <= wr_data;
   end
   assign pcr_word = pcr_q;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int GATE_BIT = PCR_EN_OFS + PCR_STRIDE * i;
      logic [WORD_W-1:0] ctrl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            ctrl_q <= '0;
         else if (wr_ctrl[i])   ctrl_q <= wr_data;
         else if (chan_done[i]) ctrl_q[START_BIT] <= 1'b0;
      end

      assign ctrl_word[i] = ctrl_q;
      assign busy[i]      = ctrl_q[START_BIT];
      assign start_raw[i] = wr_ctrl[i] && wr_data[START_BIT] && pcr_q[GATE_BIT];
   end

   if (START_REG) begin : g_start_reg
      logic [NCH-1:0] start_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) start_q <= '0;
         else        start_q <= start_raw;
      end
      assign chan_start = start_q;
   end else begin : g_start_comb
      assign chan_start = start_raw;
   end
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
   import dma_irq_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int NCH         = 7,
   parameter int ICR_OFS     = 'h0F4,
   parameter int PCR_OFS     = 'h0F0,
   parameter int CTRL_BASE   = 'h088,
   parameter int CTRL_STRIDE = 'h010,
   parameter bit START_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic [NCH-1:0]    chan_done,
   output logic [NCH-1:0]    chan_start,
   output logic              irq_req
);
   localparam int LAST_CTRL = CTRL_BASE + CTRL_STRIDE * (NCH - 1);

   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("dma_irq_ctl: NCH must lie in 1..7");
   end
   if (LAST_CTRL >= (1 << ADDR_W) || ICR_OFS >= (1 << ADDR_W)
       || PCR_OFS >= (1 << ADDR_W)) begin : g_bad_map
      $error("dma_irq_ctl: register offsets exceed ADDR_W");
   end

   logic                       w_icr, w_pcr, r_icr, r_pcr;
   logic [NCH-1:0]             w_ctrl, r_ctrl;
   logic [WORD_W-1:0]          icr_word, pcr_word;
   logic [NCH-1:0][WORD_W-1:0] ctrl_word;
   logic                       icr_master, icr_gen, icr_buserr;
   logic [NCH-1:0]             icr_flags, icr_en, ctrl_busy;

   dma_irq_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .ICR_OFS(ICR_OFS), .PCR_OFS(PCR_OFS),
                    .CTRL_BASE(CTRL_BASE), .CTRL_STRIDE(CTRL_STRIDE)) u_wdec (
      .en(wr_en), .addr(wr_addr), .hit_icr(w_icr), .hit_pcr(w_pcr), .hit_ctrl(w_ctrl));

   dma_irq_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .ICR_OFS(ICR_OFS), .PCR_OFS(PCR_OFS),
                    .CTRL_BASE(CTRL_BASE), .CTRL_STRIDE(CTRL_STRIDE)) u_rdec (
      .en(1'b1), .addr(rd_addr), .hit_icr(r_icr), .hit_pcr(r_pcr), .hit_ctrl(r_ctrl));

   dma_irq_flags #(.NCH(NCH)) u_flags (
      .clk(clk), .rst_n(rst_n), .wr_icr(w_icr), .wr_data(wr_data),
      .chan_done(chan_done), .icr_word(icr_word), .master(icr_master),
      .irq_req(irq_req), .flags(icr_flags), .enables(icr_en),
      .gen_en(icr_gen), .bus_err(icr_buserr));

   dma_irq_chan #(.NCH(NCH), .START_REG(START_REG)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_pcr(w_pcr), .wr_ctrl(w_ctrl),
      .wr_data(wr_data), .chan_done(chan_done), .pcr_word(pcr_word),
      .ctrl_word(ctrl_word), .busy(ctrl_busy), .chan_start(chan_start));

   always_comb begin
      rd_data = '0;
      if (r_icr) rd_data = rd_data | icr_word;
      if (r_pcr) rd_data = rd_data | pcr_word;
      for (int i = 0; i < NCH; i++) begin
         if (r_ctrl[i]) rd_data = rd_data | ctrl_word[i];
      end
   end
endmodule

// File: rtl/dma_irq_ctl_chk.sv
module dma_irq_ctl_chk
   import dma_irq_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int NCH         = 7,
   parameter int CTRL_BASE   = 'h088,
   parameter int CTRL_STRIDE = 'h010,
   parameter bit START_REG   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [31:0]       wr_data,
   input logic [NCH-1:0]    chan_done,
   input logic [NCH-1:0]    chan_start,
   input logic              irq_req,
   input logic              icr_master,
   input logic              icr_gen,
   input logic              icr_buserr,
   input logic [NCH-1:0]    icr_flags,
   input logic [NCH-1:0]    icr_en,
   input logic [NCH-1:0]    ctrl_busy
);
   logic [NCH-1:0] ctrl_hit;
   logic           unused_chk;
   assign unused_chk = ^wr_data;

   // R6
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);

   // R6
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (icr_master && !$past(icr_master)));

   // R5
   master_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      icr_master == ((icr_gen && (|icr_flags)) || icr_buserr));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int unsigned OFS = ctrl_offset(CTRL_BASE, CTRL_STRIDE, i);
      assign ctrl_hit[i] = wr_en && (wr_addr == ADDR_W'(OFS));

      // R4 and R7
      done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (chan_done[i] && icr_en[i]) |=> icr_flags[i]);

      // R9
      done_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (chan_done[i] && !ctrl_hit[i]) |=> !ctrl_busy[i]);

      if (START_REG) begin : g_sreg
         // R8
         start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chan_start[i] |-> $past(ctrl_hit[i] && wr_data[START_BIT]));
      end else begin : g_scomb
         // R8
         start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chan_start[i] |-> (ctrl_hit[i] && wr_data[START_BIT]));
      end
   end
endmodule

bind dma_irq_ctl dma_irq_ctl_chk #(
   .ADDR_W(ADDR_W), .NCH(NCH), .CTRL_BASE(CTRL_BASE),
   .CTRL_STRIDE(CTRL_STRIDE), .START_REG(START_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .chan_done(chan_done), .chan_start(chan_start),
   .irq_req(irq_req), .icr_master(icr_master), .icr_gen(icr_gen),
   .icr_buserr(icr_buserr), .icr_flags(icr_flags), .icr_en(icr_en),
   .ctrl_busy(ctrl_busy)
);

// File: tb/dma_irq_ctl_tb.sv
module dma_irq_ctl_tb;
   localparam int NCH = 7;

   typedef struct packed {
      logic           irq;
      logic [NCH-1:0] st;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [11:0]     wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [11:0]     rd_addr = '0;
   logic [31:0]     rd_data;
   logic [NCH-1:0]  chan_done = '0;
   logic [NCH-1:0]  chan_start;
   logic            irq_req;

   int n_chk = 0;
   int n_bad = 0;
   bit fin = 1'b0;
   exp_t q[$];
   exp_t e;

   // reference state
   logic [5:0]     m_low = '0;
   logic           m_be = 1'b0, m_gen = 1'b0, m_ms = 1'b0;
   logic [NCH-1:0] m_en = '0, m_fl = '0;
   logic [31:0]    m_pcr = '0;
   logic [31:0]    m_ctrl [NCH];

   always #10 clk = ~clk;

   dma_irq_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .chan_done(chan_done), .chan_start(chan_start), .irq_req(irq_req));

   function automatic logic [11:0] ctl(input int n);
      return 12'h088 + 12'h010 * n;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [11:0] a);
      logic [31:0] w = '0;
      if (a == 12'h0F4) begin
         w[5:0] = m_low; w[15] = m_be; w[22:16] = m_en; w[23] = m_gen;
         w[30:24] = m_fl; w[31] = m_ms;
      end else if (a == 12'h0F0) w = m_pcr;
      else for (int n = 0; n < NCH; n++) if (a == ctl(n)) w = m_ctrl[n];
      return w;
   endfunction

   // driver: one cycle of stimulus, expectation pushed to the scoreboard
   task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] dn);
      exp_t x;
      logic [NCH-1:0] clr = '0;
      logic [NCH-1:0] fl_n;
      logic be_n = m_be, gen_n = m_gen, ms_n;
      wr_en = we; wr_addr = a; wr_data = d; chan_done = dn;
      x.st = '0;
      for (int n = 0; n < NCH; n++)
         if (we && a == ctl(n) && d[24] && m_pcr[3 + 4 * n]) x.st[n] = 1'b1;
      if (we && a == 12'h0F4) begin
         clr = d[30:24]; be_n = d[15]; gen_n = d[23];
      end
      fl_n = (m_fl & ~clr) | (dn & m_en);
      ms_n = (gen_n && (|fl_n)) || be_n;
      x.irq = ms_n && !m_ms;
      q.push_back(x);
      if (we && a == 12'h0F4) begin
         m_low = d[5:0]; m_en = d[22:16];
      end
      m_be = be_n; m_gen = gen_n; m_fl = fl_n; m_ms = ms_n;
      if (we && a == 12'h0F0) m_pcr = d;
      for (int n = 0; n < NCH; n++) begin
         if (we && a == ctl(n)) m_ctrl[n] = d;
         else if (dn[n]) m_ctrl[n][24] = 1'b0;
      end
      @(negedge clk);
      wr_en = 1'b0; chan_done = '0;
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      rd_addr = a;
      #1;
      chk(tag, rd_data, m_read(a));
   endtask

   // monitor: pops one expectation per driven edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         e = q.pop_front();
         chk("R6 irq_req", {31'b0, irq_req}, {31'b0, e.irq});
         chk("R8 chan_start", {25'b0, chan_start}, {25'b0, e.st});
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         n_bad++;
         $display("FAIL R1 watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < NCH; n++) m_ctrl[n] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq_req", {31'b0, irq_req}, 32'h0);
      chk("R1 chan_start", {25'b0, chan_start}, 32'h0);
      rd(12'h0F4, "R1 icr"); rd(12'h0F0, "R1 pcr"); rd(ctl(0), "R1 ctrl0");

      // R2 writable fields, R5 bus error drives summary, R6 pulse
      cyc(1, 12'h0F4, 32'hFFFF_FFFF, '0);
      rd(12'h0F4, "R2 icr all ones");
      chk("R2 hole bits", rd_data & 32'h0000_7FC0, 32'h0);
      cyc(1, 12'h0F4, 32'h00FF_803F, '0);   // R6 no second pulse
      rd(12'h0F4, "R6 icr held");
      cyc(1, 12'h0F4, 32'h0080_0000, '0);   // R5 summary clears
      rd(12'h0F4, "R5 icr gen only");

      // R4 done without enable ignored
      cyc(0, '0, '0, 7'b000_0100);
      rd(12'h0F4, "R4 done ignored");
      cyc(1, 12'h0F4, 32'h00FF_0000, '0);
      cyc(0, '0, '0, 7'b000_0100);          // R4/R6 flag 26, pulse
      rd(12'h0F4, "R4 flag ch2");
      cyc(0, '0, '0, 7'b010_0000);          // R6 no pulse while set
      rd(12'h0F4, "R4 flag ch5");

      // R3 write-one-to-clear
      cyc(1, 12'h0F4, 32'h00FF_0000, '0);
      rd(12'h0F4, "R3 zero keeps flags");
      cyc(1, 12'h0F4, 32'h04FF_0000, '0);
      rd(12'h0F4, "R3 clear ch2");
      // R7 collision
      cyc(1, 12'h0F4, 32'h20FF_0000, 7'b010_0000);
      rd(12'h0F4, "R7 done wins");
      cyc(1, 12'h0F4, 32'h20FF_0000, '0);
      rd(12'h0F4, "R3 clear ch5");
      cyc(0, '0, '0, 7'b000_0001);          // R6 new rise
      cyc(1, 12'h0F4, 32'h01FF_0000, '0);
      // R5 flag without global enable
      cyc(1, 12'h0F4, 32'h007F_0000, '0);
      cyc(0, '0, '0, 7'b000_0010);
      rd(12'h0F4, "R5 no gen no summary");
      cyc(1, 12'h0F4, 32'h00FF_0000, '0);   // R5 gen on -> rise
      rd(12'h0F4, "R5 gen with flag");
      cyc(1, 12'h0F4, 32'h02FF_0000, '0);

      // R8 start gating, R10 storage
      cyc(1, 12'h0F0, 32'h0000_0008, '0);
      rd(12'h0F0, "R10 pcr");
      cyc(1, ctl(0), 32'h0100_0002, '0);
      rd(ctl(0), "R10 ctrl0");
      cyc(1, ctl(1), 32'h0100_0000, '0);    // R8 gated off
      // R9 done drops start bit
      cyc(0, '0, '0, 7'b000_0001);
      rd(ctl(0), "R9 ctrl0 after done");
      cyc(1, 12'h0F4, 32'h01FF_0000, '0);
      cyc(1, 12'h0F0, 32'h0888_8888, '0);
      cyc(1, ctl(6), 32'h0100_0000, '0);
      cyc(1, ctl(3), 32'h0000_0005, '0);    // R8 no start bit
      rd(ctl(3), "R10 ctrl3");
      cyc(1, ctl(6), 32'h0100_0001, 7'b100_0000);   // R9 write wins
      rd(ctl(6), "R9 write beats done");
      rd(12'h0F4, "R4 ch6 flag");

      // R11 unmapped offsets
      rd(12'h0F8, "R11 unmapped");
      rd(12'h084, "R11 unmapped low");

      repeat (3) @(negedge clk);
      fin = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule